// File: doc/BRIEF.md
# Dual-Bus Register File Datapath

This block holds the working registers of a small 16-bit processor: an accumulator, four general registers, a program counter, a stack pointer and a hidden operand register. The registers share two internal buses. The data bus carries values between registers and brings in values from outside. The address bus carries a memory pointer. Each register loads from the data bus under its own load strobe. It can drive either bus under its own output enable. The accumulator is the exception: it can never act as a pointer. The operand register is also special. A mode-driven enable places it on the address bus for direct addressing, or on the data bus for immediate addressing.

An external source, such as memory read data, can drive the data bus through its own enable. The accumulator has a second load path from the ALU result. The block resolves both buses in every cycle and flags contention when more than one source drives a bus. It presents the resolved bus values, the contention flags and the accumulator as registered outputs.

Top module: `dual_bus_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. The cycle after reset, the outputs `dbus_q`, `abus_q`, `dbus_err`, `abus_err` and `acc_q` are zero.
- R2: Register indices are A=0, B=1, C=2, D=3, E=4, PC=5, SP=6, OPR=7. When `load_en[i]` is high at a rising edge, register i takes the data-bus value of that cycle. A register whose strobe is low keeps its value, including while it drives a bus.
- R3: When `dbus_oe[i]` is high, register i is a data-bus source. The resolved data bus appears on `dbus_q` one cycle later.
- R4: When `abus_oe[i]` is high for i from 1 to 7, register i is an address-bus source. The resolved address bus appears on `abus_q` one cycle later.
- R5: `abus_oe[0]` (the accumulator) has no effect. It adds no source to the address bus and adds nothing to its contention count.
- R6: When `opr_oe` is high, the operand register drives the address bus if `opr_direct` is 1 and the data bus if `opr_direct` is 0. When it is also enabled through the matching bit 7 of `dbus_oe` or `abus_oe`, it still counts as a single source.
- R7: When `alu_load` is high, the accumulator takes `alu_res` at the edge. This holds whatever the value of `load_en[0]`.
- R8: A bus with no enabled source reads as zero.
- R9: When two or more sources are enabled on one bus, that bus's error flag (`dbus_err` or `abus_err`) is 1 in the next cycle. The bus value is then the bitwise OR of the enabled sources. With at most one source, the flag is 0.
- R10: When `ext_en` is high, `ext_data` is a data-bus source. It takes part in loads and in contention like a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 8 | Per-register data-bus load strobes, index as in R2 |
| dbus_oe | input | 8 | Per-register data-bus output enables |
| abus_oe | input | 8 | Per-register address-bus output enables, bit 0 ignored |
| opr_oe | input | 1 | Mode-driven operand register output enable |
| opr_direct | input | 1 | 1: operand register drives the address bus, 0: the data bus |
| ext_en | input | 1 | External data-bus source enable |
| ext_data | input | 16 | External data-bus source value |
| alu_load | input | 1 | Load accumulator from the ALU result |
| alu_res | input | 16 | ALU result |
| dbus_q | output | 16 | Registered resolved data bus |
| abus_q | output | 16 | Registered resolved address bus |
| dbus_err | output | 1 | Registered data-bus contention flag |
| abus_err | output | 1 | Registered address-bus contention flag |
| acc_q | output | 16 | Accumulator contents |

## Verification
The bench builds the block with its default 16-bit width and the fixed set of eight registers. Directed phases first load distinct patterns into every register through the external source. They then read each register back over each bus, check that the accumulator's address-bus enable is ignored, cover both operand modes, test the ALU-load priority, check idle and contended buses, and apply a reset in the middle of a run. A long random phase follows in which enables overlap freely. This brings OR-resolved contention, register-to-register moves and simultaneous load and drive on the same register within reach. A behavioural model checks every one of these cycles.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned IDX_W = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    RID_ACC = 3'd0,
    RID_B   = 3'd1,
    RID_C   = 3'd2,
    RID_D   = 3'd3,
    RID_E   = 3'd4,
    RID_PC  = 3'd5,
    RID_SP  = 3'd6,
    RID_OPR = 3'd7
  } reg_id_e;

  // address-bus sources exclude the accumulator
  localparam int unsigned ABUS_SRCS = NREG - 1;
  // data-bus sources: every register plus the external source
  localparam int unsigned DBUS_SRCS = NREG + 1;
endpackage

// File: rtl/reg_cell.sv
module reg_cell #(
  parameter int unsigned W = 16,
  parameter bit HAS_ALU = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         alu_ld,
  input  logic [W-1:0] alu_d,
  output logic [W-1:0] q
);
  logic alu_sel;
  assign alu_sel = HAS_ALU ? alu_ld : 1'b0;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (alu_sel) q <= alu_d;
    else if (ld)      q <= d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !alu_sel) |=> $stable(q));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !alu_sel) |=> (q == $past(d)));
  // R7
  alu_prio_chk: assert property (@(posedge clk) disable iff (rst)
    alu_sel |=> (q == $past(alu_d)));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import regfile_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   load_en,
  input  logic [W-1:0]      dbus,
  input  logic              alu_load,
  input  logic [W-1:0]      alu_res,
  output logic [NREG*W-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(RID_ACC)) begin : g_acc
      reg_cell #(.W(W), .HAS_ALU(1'b1)) cell_i (
        .clk(clk), .rst(rst), .ld(load_en[i]), .d(dbus),
        .alu_ld(alu_load), .alu_d(alu_res), .q(regs_flat[i*W +: W])
      );
    end else begin : g_plain
      reg_cell #(.W(W), .HAS_ALU(1'b0)) cell_i (
        .clk(clk), .rst(rst), .ld(load_en[i]), .d(dbus),
        .alu_ld(1'b0), .alu_d('0), .q(regs_flat[i*W +: W])
      );
    end
  end
endmodule

// File: rtl/bus_resolver.sv
module bus_resolver #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] src_flat,
  output logic [W-1:0]   bus,
  output logic [W-1:0]   bus_q,
  output logic           err_q
);
  logic seen;
  logic multi;

  always_comb begin
    bus   = '0;
    seen  = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en[i]) begin
        bus   = bus | src_flat[i*W +: W];
        multi = multi | seen;
        seen  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      err_q <= 1'b0;
    end else begin
      bus_q <= bus;
      err_q <= multi;
    end
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> (bus_q == '0));
  // R9
  contention_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(en) > 1) |=> err_q);
  // R9
  no_false_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(en) <= 1) |=> !err_q);
endmodule

// File: rtl/dual_bus_regfile.sv
module dual_bus_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] load_en,
  input  logic [NREG-1:0] dbus_oe,
  input  logic [NREG-1:0] abus_oe,
  input  logic            opr_oe,
  input  logic            opr_direct,
  input  logic            ext_en,
  input  logic [W-1:0]    ext_data,
  input  logic            alu_load,
  input  logic [W-1:0]    alu_res,
  output logic [W-1:0]    dbus_q,
  output logic [W-1:0]    abus_q,
  output logic            dbus_err,
  output logic            abus_err,
  output logic [W-1:0]    acc_q
);
  localparam int unsigned OPR_I = int'(RID_OPR);

  logic [NREG*W-1:0]      regs_flat;
  logic [W-1:0]           dbus;
  logic [W-1:0]           abus;
  logic [DBUS_SRCS-1:0]   d_en;
  logic [DBUS_SRCS*W-1:0] d_src;
  logic [ABUS_SRCS-1:0]   a_en;
  logic [ABUS_SRCS*W-1:0] a_src;

  // data-bus sources: registers 0..NREG-1, then the external source
  for (genvar i = 0; i < NREG; i++) begin : g_dsrc
    if (i == OPR_I) begin : g_opr
      assign d_en[i] = dbus_oe[i] | (opr_oe & ~opr_direct);
    end else begin : g_reg
      assign d_en[i] = dbus_oe[i];
    end
    assign d_src[i*W +: W] = regs_flat[i*W +: W];
  end
  assign d_en[NREG]           = ext_en;
  assign d_src[NREG*W +: W]   = ext_data;

  // address-bus sources: registers 1..NREG-1, accumulator left out
  for (genvar j = 0; j < ABUS_SRCS; j++) begin : g_asrc
    if (j + 1 == OPR_I) begin : g_opr
      assign a_en[j] = abus_oe[j+1] | (opr_oe & opr_direct);
    end else begin : g_reg
      assign a_en[j] = abus_oe[j+1];
    end
    assign a_src[j*W +: W] = regs_flat[(j+1)*W +: W];
  end

  bus_resolver #(.W(W), .N(DBUS_SRCS)) dres_i (
    .clk(clk), .rst(rst), .en(d_en), .src_flat(d_src),
    .bus(dbus), .bus_q(dbus_q), .err_q(dbus_err)
  );

  bus_resolver #(.W(W), .N(ABUS_SRCS)) ares_i (
    .clk(clk), .rst(rst), .en(a_en), .src_flat(a_src),
    .bus(abus), .bus_q(abus_q), .err_q(abus_err)
  );

  reg_bank #(.W(W)) bank_i (
    .clk(clk), .rst(rst), .load_en(load_en), .dbus(dbus),
    .alu_load(alu_load), .alu_res(alu_res), .regs_flat(regs_flat)
  );

  assign acc_q = regs_flat[int'(RID_ACC)*W +: W];

  // R5
  acc_never_pointer_chk: assert property (@(posedge clk) disable iff (rst)
    (abus_oe[0] && abus_oe[NREG-1:1] == '0 && !(opr_oe && opr_direct))
      |=> (abus_q == '0 && !abus_err));
  // R6
  opr_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (opr_oe && opr_direct && abus_oe[NREG-2:1] == '0)
      |=> (abus_q == $past(regs_flat[OPR_I*W +: W]) && !abus_err));
  // R6
  opr_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (opr_oe && !opr_direct && dbus_oe[NREG-2:0] == '0 && !ext_en)
      |=> (dbus_q == $past(regs_flat[OPR_I*W +: W]) && !dbus_err));
  // R10
  ext_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_en && dbus_oe == '0 && !opr_oe) |=> (dbus_q == $past(ext_data)));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (dbus_q == '0 && abus_q == '0 && !dbus_err && !abus_err));
endmodule

// File: tb/dual_bus_regfile_tb_top.sv
module dual_bus_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  load_en, dbus_oe, abus_oe;
  logic        opr_oe, opr_direct, ext_en, alu_load;
  logic [15:0] ext_data, alu_res;
  logic [15:0] dbus_q, abus_q, acc_q;
  logic        dbus_err, abus_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_r [8];
  logic [15:0] e_db, e_ab;
  logic        e_de, e_ae;

  always #5 clk = ~clk;

  dual_bus_regfile dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .dbus_oe(dbus_oe),
    .abus_oe(abus_oe), .opr_oe(opr_oe), .opr_direct(opr_direct),
    .ext_en(ext_en), .ext_data(ext_data), .alu_load(alu_load),
    .alu_res(alu_res), .dbus_q(dbus_q), .abus_q(abus_q),
    .dbus_err(dbus_err), .abus_err(abus_err), .acc_q(acc_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; load_en = '0; dbus_oe = '0; abus_oe = '0; opr_oe = 0;
    opr_direct = 0; ext_en = 0; ext_data = '0; alu_load = 0; alu_res = '0;
  endtask

  // one clock: model the cycle, clock it, compare all outputs
  task automatic step(input string tag);
    logic [15:0] db, ab;
    int dn, an;
    db = '0; ab = '0; dn = 0; an = 0;
    for (int i = 0; i < 8; i++) begin
      if (dbus_oe[i] || (i == 7 && opr_oe && !opr_direct)) begin
        db |= m_r[i]; dn++;
      end
      if (i != 0 && (abus_oe[i] || (i == 7 && opr_oe && opr_direct))) begin
        ab |= m_r[i]; an++;
      end
    end
    if (ext_en) begin db |= ext_data; dn++; end
    if (rst) begin
      for (int i = 0; i < 8; i++) m_r[i] = '0;
      e_db = '0; e_ab = '0; e_de = 0; e_ae = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (i == 0 && alu_load) m_r[i] = alu_res;
        else if (load_en[i]) m_r[i] = db;
      end
      e_db = db; e_ab = ab; e_de = (dn > 1); e_ae = (an > 1);
    end
    @(posedge clk);
    #1;
    chk(tag, "dbus_q", dbus_q, e_db);
    chk(tag, "abus_q", abus_q, e_ab);
    chk(tag, "dbus_err", {15'd0, dbus_err}, {15'd0, e_de});
    chk(tag, "abus_err", {15'd0, abus_err}, {15'd0, e_ae});
    chk(tag, "acc_q", acc_q, m_r[0]);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    step("R1"); step("R1");
    idle();
    // R10 / R2: load distinct patterns through the external source
    for (int i = 0; i < 8; i++) begin
      idle(); ext_en = 1; ext_data = 16'h1111 * (i + 1) ^ 16'h0F0F;
      load_en[i] = 1; step("R10");
    end
    // R3: read each over the data bus
    for (int i = 0; i < 8; i++) begin idle(); dbus_oe[i] = 1; step("R3"); end
    // R4: read B..OPR over the address bus
    for (int i = 1; i < 8; i++) begin idle(); abus_oe[i] = 1; step("R4"); end
    // R5: accumulator address enable ignored
    idle(); abus_oe[0] = 1; step("R5");
    idle(); abus_oe[0] = 1; abus_oe[3] = 1; step("R5");
    // R6: operand register modes
    idle(); opr_oe = 1; opr_direct = 1; step("R6");
    idle(); opr_oe = 1; opr_direct = 0; step("R6");
    idle(); opr_oe = 1; opr_direct = 0; dbus_oe[7] = 1; step("R6");
    idle(); opr_oe = 1; opr_direct = 1; abus_oe[7] = 1; step("R6");
    // R7: ALU load wins over data-bus load
    idle(); alu_load = 1; alu_res = 16'hBEEF; load_en[0] = 1;
    ext_en = 1; ext_data = 16'h0123; step("R7");
    idle(); dbus_oe[0] = 1; step("R7");
    // R8: idle buses
    idle(); step("R8");
    // R9: contention
    idle(); dbus_oe[1] = 1; dbus_oe[2] = 1; step("R9");
    idle(); abus_oe[1] = 1; abus_oe[6] = 1; step("R9");
    idle(); dbus_oe[4] = 1; ext_en = 1; ext_data = 16'h8001; load_en[5] = 1; step("R9");
    idle(); dbus_oe[5] = 1; step("R9");
    // R2: register-to-register move and self-hold while driving
    idle(); dbus_oe[1] = 1; load_en[2] = 1; abus_oe[2] = 1; step("R2");
    idle(); dbus_oe[2] = 1; abus_oe[1] = 1; step("R2");
    // R1: reset mid-run while strobes are active
    idle(); rst = 1; load_en = 8'hFF; ext_en = 1; ext_data = 16'hFFFF; step("R1");
    for (int i = 0; i < 8; i++) begin idle(); dbus_oe[i] = 1; step("R1"); end
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int i = 0; i < 8; i++) begin
        load_en[i] = ($urandom_range(0, 5) == 0);
        dbus_oe[i] = ($urandom_range(0, 7) == 0);
        abus_oe[i] = ($urandom_range(0, 6) == 0);
      end
      opr_oe = ($urandom_range(0, 5) == 0);
      opr_direct = $urandom_range(0, 1);
      ext_en = ($urandom_range(0, 2) == 0);
      ext_data = 16'($urandom);
      alu_load = ($urandom_range(0, 6) == 0);
      alu_res = 16'($urandom);
      rst = ($urandom_range(0, 400) == 0);
      step("R2 R3 R4 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule